// File: doc/BRIEF.md
# Way-Partitioned Cache Replacement Controller

This unit does the tag lookup and chooses the replacement way for a set-associative cache shared by several requesters. Each requester owns a private register that names its service class. Each class has an entry in a shared table of way masks. A lookup hits when its tag matches in any valid way of the addressed set, whatever the requester's class. A miss allocates the line only into a way that the requester's class mask allows. That way is the lowest-numbered permitted empty way if one exists. Otherwise it is the least recently used permitted way.

A mask write is accepted only if its ones form a single unbroken run with at least one bit set. A write that breaks this rule is dropped and raises an error pulse. Two disjoint masks, such as 0x00003 (ways 0 and 1) and 0xFFFFC (ways 2 to 19), split the cache between two classes. Each still sees hits in the other's ways. Recency is kept per set as a permutation of ages: age 0 means most recently used.

A lookup is presented for one cycle. Its result is registered and appears in the following cycle. The tag, valid and age state is updated on the same clock edge, so a lookup in the next cycle already sees the fill. The defaults are 20 ways, 16 classes, 4 requesters, 16 sets and 12-bit tags. The way count may not exceed 31.

Top module: `wpart_repl_ctrl`

## Requirements
- R1: After reset, every class mask is 0xFFFFF, every requester selects class 0, every line is invalid, and rsp_valid and mask_err are 0.
- R2: rsp_valid is 1 in exactly those cycles that follow a cycle with lk_valid at 1.
- R3: A lookup whose tag matches a valid line in the set reports rsp_hit=1 and that line's way on rsp_way. This holds even when the way lies outside the requester's mask. A hit never evicts.
- R4: On a miss, the line is written into a way whose bit is 1 in the mask of the requester's current class (bit i is way i), and rsp_way reports that way.
- R5: On a miss, if any permitted way is invalid, the lowest-numbered such way is used and rsp_evict is 0.
- R6: On a miss with every permitted way valid, the least recently used permitted way is replaced. rsp_evict is 1 and rsp_victim_tag carries the tag it held.
- R7: A hit in any way, and a fill, both make the accessed way the most recently used in its set.
- R8: A mask write whose value is non-zero and has one contiguous run of ones is stored for class mask_idx. It governs lookups from the next cycle on.
- R9: A mask write that is zero or has more than one run of ones leaves the stored mask unchanged. It sets mask_err to 1 for the single following cycle.
- R10: A class-select write sets the class of requester cls_req to cls_val. Other requesters are unaffected.
- R11: A lookup presented in the same cycle as a class-select or mask write uses the class and mask values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_we | input | 1 | Class-select write strobe |
| cls_req | input | 2 | Requester whose class is written |
| cls_val | input | 4 | New class number |
| mask_we | input | 1 | Mask write strobe |
| mask_idx | input | 4 | Class whose mask is written |
| mask_val | input | 20 | Proposed way mask |
| mask_err | output | 1 | Pulse: previous mask write was rejected |
| lk_valid | input | 1 | Lookup strobe |
| lk_req | input | 2 | Requester issuing the lookup |
| lk_set | input | 4 | Set index |
| lk_tag | input | 12 | Tag looked up |
| rsp_valid | output | 1 | Result of the previous cycle's lookup is valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 5 | Way hit or way filled |
| rsp_evict | output | 1 | Fill replaced a valid line |
| rsp_victim_tag | output | 12 | Tag of the replaced line |

## Verification
Faulty recency or valid state shows up at the ports as a wrong rsp_way or victim tag on a later miss to that set. That miss can come many lookups after the corrupting access. For this reason the random traffic is confined to a few sets with a small tag pool, so that eviction decisions come often and soon. A corrupted mask or class register shows up as a fill outside the expected ways, starting with the very next miss from an affected requester. A wrong legality decision is visible one cycle later on mask_err, and in later fills.

// File: rtl/wpart_pkg.sv
package wpart_pkg;
  localparam int DEF_WAYS    = 20;
  localparam int DEF_CLASSES = 16;
  localparam int DEF_REQS    = 4;
  localparam int DEF_SETS    = 16;
  localparam int DEF_TAG_W   = 12;

  // Non-zero and one contiguous run of ones. Adding the lowest set bit
  // carries through the run; a single run leaves no overlap with m.
  function automatic logic mask_legal(input logic [31:0] m);
    logic [31:0] low_bit;
    logic [31:0] carried;
    low_bit = m & (~m + 32'd1);
    carried = m + low_bit;
    return (m != 32'd0) && ((carried & m) == 32'd0);
  endfunction
endpackage

// File: rtl/wpart_cfg_regs.sv
module wpart_cfg_regs #(
  parameter int NUM_WAYS    = wpart_pkg::DEF_WAYS,
  parameter int NUM_CLASSES = wpart_pkg::DEF_CLASSES,
  parameter int NUM_REQS    = wpart_pkg::DEF_REQS,
  localparam int CLS_W = $clog2(NUM_CLASSES),
  localparam int REQ_W = $clog2(NUM_REQS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cls_we,
  input  logic [REQ_W-1:0]    cls_req,
  input  logic [CLS_W-1:0]    cls_val,
  input  logic                mask_we,
  input  logic [CLS_W-1:0]    mask_idx,
  input  logic [NUM_WAYS-1:0] mask_val,
  input  logic [REQ_W-1:0]    lk_req,
  output logic [NUM_WAYS-1:0] cur_mask,
  output logic                mask_err
);
  logic [CLS_W-1:0]    cls_q  [NUM_REQS];
  logic [NUM_WAYS-1:0] mask_q [NUM_CLASSES];
  logic                wr_legal;

  assign wr_legal = wpart_pkg::mask_legal(32'(mask_val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REQS; r++) cls_q[r] <= '0;
      for (int c = 0; c < NUM_CLASSES; c++) mask_q[c] <= '1;
      mask_err <= 1'b0;
    end else begin
      if (cls_we) cls_q[cls_req] <= cls_val;
      if (mask_we && wr_legal) mask_q[mask_idx] <= mask_val;
      mask_err <= mask_we && !wr_legal;
    end
  end

  assign cur_mask = mask_q[cls_q[lk_req]];
endmodule

// File: rtl/wpart_set_store.sv
module wpart_set_store #(
  parameter int NUM_SETS = wpart_pkg::DEF_SETS,
  parameter int NUM_WAYS = wpart_pkg::DEF_WAYS,
  parameter int TAG_W    = wpart_pkg::DEF_TAG_W,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int AGE_W = $clog2(NUM_WAYS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SET_W-1:0]                rd_set,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]  rd_tags,
  output logic [NUM_WAYS-1:0]             rd_valid,
  output logic [NUM_WAYS-1:0][AGE_W-1:0]  rd_ages,
  input  logic                            touch_en,
  input  logic [AGE_W-1:0]                touch_way,
  input  logic                            fill_en,
  input  logic [TAG_W-1:0]                fill_tag
);
  typedef logic [NUM_WAYS-1:0][AGE_W-1:0] age_vec_t;

  // Touched way becomes age 0; ways younger than it grow one step older.
  function automatic age_vec_t age_after_touch(input age_vec_t a, input logic [AGE_W-1:0] w);
    age_vec_t res;
    logic [AGE_W-1:0] pivot;
    pivot = a[w];
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (AGE_W'(i) == w)   res[i] = '0;
      else if (a[i] < pivot) res[i] = a[i] + AGE_W'(1);
      else                   res[i] = a[i];
    end
    return res;
  endfunction

  logic [NUM_WAYS-1:0][TAG_W-1:0] row_tags  [NUM_SETS];
  logic [NUM_WAYS-1:0]            row_valid [NUM_SETS];
  age_vec_t                       row_ages  [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q;
    logic [NUM_WAYS-1:0]            val_q;
    age_vec_t                       age_q;
    logic                           sel;

    assign sel = (rd_set == SET_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q <= '0;
        val_q <= '0;
        for (int w = 0; w < NUM_WAYS; w++) age_q[w] <= AGE_W'(w);
      end else if (sel) begin
        if (touch_en) age_q <= age_after_touch(age_q, touch_way);
        if (fill_en) begin
          tag_q[touch_way] <= fill_tag;
          val_q[touch_way] <= 1'b1;
        end
      end
    end

    assign row_tags[s]  = tag_q;
    assign row_valid[s] = val_q;
    assign row_ages[s]  = age_q;
  end

  assign rd_tags  = row_tags[rd_set];
  assign rd_valid = row_valid[rd_set];
  assign rd_ages  = row_ages[rd_set];
endmodule

// File: rtl/wpart_victim_pick.sv
module wpart_victim_pick #(
  parameter int NUM_WAYS = wpart_pkg::DEF_WAYS,
  localparam int AGE_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]            valid,
  input  logic [NUM_WAYS-1:0][AGE_W-1:0] ages,
  input  logic [NUM_WAYS-1:0]            allow,
  output logic [AGE_W-1:0]               victim_way,
  output logic                           victim_valid
);
  function automatic logic [AGE_W:0] first_free(input logic [NUM_WAYS-1:0] v,
                                                input logic [NUM_WAYS-1:0] m);
    logic [AGE_W:0] res;
    res = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (m[i] && !v[i]) res = {1'b1, AGE_W'(i)};
    return res;
  endfunction

  function automatic logic [AGE_W-1:0] oldest(input logic [NUM_WAYS-1:0][AGE_W-1:0] a,
                                              input logic [NUM_WAYS-1:0] m);
    logic [AGE_W-1:0] best;
    logic [AGE_W-1:0] best_age;
    logic             have;
    best = '0; best_age = '0; have = 1'b0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (m[i] && (!have || a[i] > best_age)) begin
        best = AGE_W'(i); best_age = a[i]; have = 1'b1;
      end
    end
    return best;
  endfunction

  logic [AGE_W:0] free_pick;

  always_comb begin
    free_pick = first_free(valid, allow);
    if (free_pick[AGE_W]) begin
      victim_way   = free_pick[AGE_W-1:0];
      victim_valid = 1'b0;
    end else begin
      victim_way   = oldest(ages, allow);
      victim_valid = 1'b1;
    end
  end
endmodule

// File: rtl/wpart_repl_ctrl.sv
module wpart_repl_ctrl #(
  parameter int NUM_WAYS    = wpart_pkg::DEF_WAYS,
  parameter int NUM_CLASSES = wpart_pkg::DEF_CLASSES,
  parameter int NUM_REQS    = wpart_pkg::DEF_REQS,
  parameter int NUM_SETS    = wpart_pkg::DEF_SETS,
  parameter int TAG_W       = wpart_pkg::DEF_TAG_W,
  localparam int CLS_W = $clog2(NUM_CLASSES),
  localparam int REQ_W = $clog2(NUM_REQS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cls_we,
  input  logic [REQ_W-1:0]    cls_req,
  input  logic [CLS_W-1:0]    cls_val,
  input  logic                mask_we,
  input  logic [CLS_W-1:0]    mask_idx,
  input  logic [NUM_WAYS-1:0] mask_val,
  output logic                mask_err,
  input  logic                lk_valid,
  input  logic [REQ_W-1:0]    lk_req,
  input  logic [SET_W-1:0]    lk_set,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [WAY_W-1:0]    rsp_way,
  output logic                rsp_evict,
  output logic [TAG_W-1:0]    rsp_victim_tag
);
  logic [NUM_WAYS-1:0]            cur_mask;
  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tags;
  logic [NUM_WAYS-1:0]            rd_valid;
  logic [NUM_WAYS-1:0][WAY_W-1:0] rd_ages;
  logic [NUM_WAYS-1:0]            tag_match;
  logic                           hit_any;
  logic [WAY_W-1:0]               hit_way;
  logic [WAY_W-1:0]               victim_way;
  logic                           victim_valid;
  // Named internal events, observed by the bound checker.
  logic                           hit_en;
  logic                           fill_en;
  logic [WAY_W-1:0]               touch_way;

  wpart_cfg_regs #(.NUM_WAYS(NUM_WAYS), .NUM_CLASSES(NUM_CLASSES), .NUM_REQS(NUM_REQS)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cls_we(cls_we), .cls_req(cls_req), .cls_val(cls_val),
    .mask_we(mask_we), .mask_idx(mask_idx), .mask_val(mask_val),
    .lk_req(lk_req), .cur_mask(cur_mask), .mask_err(mask_err)
  );

  wpart_set_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_set(lk_set),
    .rd_tags(rd_tags), .rd_valid(rd_valid), .rd_ages(rd_ages),
    .touch_en(lk_valid), .touch_way(touch_way),
    .fill_en(fill_en), .fill_tag(lk_tag)
  );

  wpart_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .valid(rd_valid), .ages(rd_ages), .allow(cur_mask),
    .victim_way(victim_way), .victim_valid(victim_valid)
  );

  // Hits ignore the class mask entirely.
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign tag_match[w] = rd_valid[w] && (rd_tags[w] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (tag_match[i]) hit_way = WAY_W'(i);
  end

  assign hit_any   = |tag_match;
  assign hit_en    = lk_valid && hit_any;
  assign fill_en   = lk_valid && !hit_any;
  assign touch_way = hit_any ? hit_way : victim_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_way        <= '0;
      rsp_evict      <= 1'b0;
      rsp_victim_tag <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit        <= hit_any;
        rsp_way        <= touch_way;
        rsp_evict      <= !hit_any && victim_valid;
        rsp_victim_tag <= (!hit_any && victim_valid) ? rd_tags[victim_way] : '0;
      end
    end
  end
endmodule

// File: rtl/wpart_repl_ctrl_chk.sv
module wpart_repl_ctrl_chk #(
  parameter int NUM_WAYS = wpart_pkg::DEF_WAYS,
  parameter int TAG_W    = wpart_pkg::DEF_TAG_W,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lk_valid,
  input logic                mask_we,
  input logic                mask_err,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic                rsp_evict,
  input logic [WAY_W-1:0]    rsp_way,
  input logic [TAG_W-1:0]    rsp_victim_tag,
  input logic [NUM_WAYS-1:0] cur_mask,
  input logic                fill_en,
  input logic                hit_en,
  input logic [WAY_W-1:0]    touch_way
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_rsp_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid));

  assert_fill_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> cur_mask[touch_way]);

  assert_mask_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (cur_mask != '0));

  assert_err_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_err |-> $past(mask_we));

  assert_way_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (32'(rsp_way) < NUM_WAYS));

  assert_hit_no_evict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en |=> (rsp_hit && !rsp_evict && rsp_victim_tag == '0));
endmodule

bind wpart_repl_ctrl wpart_repl_ctrl_chk #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .mask_we(mask_we),
  .mask_err(mask_err), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_evict(rsp_evict), .rsp_way(rsp_way), .rsp_victim_tag(rsp_victim_tag),
  .cur_mask(cur_mask), .fill_en(fill_en), .hit_en(hit_en), .touch_way(touch_way)
);

// File: tb/wpart_repl_ctrl_test.sv
module wpart_repl_ctrl_test;
  localparam int W = 20, NC = 16, NR = 4, NS = 16, TW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cls_we = 0; logic [1:0] cls_req = 0; logic [3:0] cls_val = 0;
  logic mask_we = 0; logic [3:0] mask_idx = 0; logic [W-1:0] mask_val = 0;
  logic mask_err;
  logic lk_valid = 0; logic [1:0] lk_req = 0; logic [3:0] lk_set = 0; logic [TW-1:0] lk_tag = 0;
  logic rsp_valid, rsp_hit, rsp_evict; logic [4:0] rsp_way; logic [TW-1:0] rsp_victim_tag;

  always #4 clk = ~clk;

  wpart_repl_ctrl uut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference state
  int m_tag [NS][W]; bit m_val [NS][W]; int m_age [NS][W];
  int m_cls [NR]; int m_mask [NC];

  function automatic bit legal_ref(int m);
    int runs = 0;
    for (int i = 0; i < W; i++)
      if (m[i] && (i == 0 || !m[i-1])) runs++;
    return runs == 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < W; w++) begin m_tag[s][w] = 0; m_val[s][w] = 0; m_age[s][w] = w; end
    for (int r = 0; r < NR; r++) m_cls[r] = 0;
    for (int c = 0; c < NC; c++) m_mask[c] = 'hFFFFF;
  endtask

  // One clock: drive, predict, advance, compare. lbl "" = auto label.
  task automatic step(bit lv, int rq, int st, int tg, bit cw, int cr, int cv,
                      bit mw, int mi, int mv, string lbl);
    bit e_hit, e_ev; int e_way, e_vt, mk, pivot; bit e_err;
    string lab;
    lk_valid = lv; lk_req = rq[1:0]; lk_set = st[3:0]; lk_tag = tg[TW-1:0];
    cls_we = cw; cls_req = cr[1:0]; cls_val = cv[3:0];
    mask_we = mw; mask_idx = mi[3:0]; mask_val = mv[W-1:0];
    e_hit = 0; e_ev = 0; e_way = 0; e_vt = 0;
    if (lv) begin
      mk = m_mask[m_cls[rq]];           // R11: old config
      for (int i = W - 1; i >= 0; i--)
        if (m_val[st][i] && m_tag[st][i] == tg) begin e_hit = 1; e_way = i; end
      if (!e_hit) begin
        e_way = -1;
        for (int i = W - 1; i >= 0; i--) if (mk[i] && !m_val[st][i]) e_way = i;
        if (e_way < 0) begin
          pivot = -1;
          for (int i = 0; i < W; i++) if (mk[i] && m_age[st][i] > pivot) begin pivot = m_age[st][i]; e_way = i; end
          e_ev = 1; e_vt = m_tag[st][e_way];
        end
      end
      pivot = m_age[st][e_way];
      for (int i = 0; i < W; i++) if (m_age[st][i] < pivot) m_age[st][i]++;
      m_age[st][e_way] = 0;
      if (!e_hit) begin m_tag[st][e_way] = tg; m_val[st][e_way] = 1; end
    end
    e_err = mw && !legal_ref(mv);
    if (mw && !e_err) m_mask[mi] = mv & 'hFFFFF;
    if (cw) m_cls[cr] = cv;
    @(posedge clk); @(negedge clk);
    lk_valid = 0; cls_we = 0; mask_we = 0;
    check("R2", "rsp_valid", int'(rsp_valid), int'(lv));
    check(mw ? "R9" : "R8", "mask_err", int'(mask_err), int'(e_err));
    if (lv) begin
      lab = (lbl != "") ? lbl : (e_hit ? "R3" : (e_ev ? "R6" : "R5"));
      check(lab, "rsp_hit", int'(rsp_hit), int'(e_hit));
      check(lab, "rsp_way", int'(rsp_way), e_way);
      check(lab, "rsp_evict", int'(rsp_evict), int'(e_ev));
      check(lab, "rsp_victim_tag", int'(rsp_victim_tag), e_vt);
    end
  endtask

  task automatic look(int rq, int st, int tg, string lbl);
    step(1, rq, st, tg, 0, 0, 0, 0, 0, 0, lbl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state at the ports
    check("R1", "rsp_valid", int'(rsp_valid), 0);
    check("R1", "mask_err", int'(mask_err), 0);
    look(2, 3, 'h55, "R1");           // full mask, class 0, empty set -> way 0
    look(2, 3, 'h56, "R1");           // -> way 1
    // R8 / R10: split the cache
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 'h00003, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 'hFFFFC, "R8");
    step(0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 1, 1, 2, 0, 0, 0, "R10");
    look(0, 5, 'hA, "R4");            // way 0
    look(0, 5, 'hB, "R4");            // way 1
    look(0, 5, 'hC, "R6");            // evicts A in way 0
    look(0, 5, 'hB, "R7");            // hit way 1, becomes MRU
    look(0, 5, 'hD, "R7");            // evicts C in way 0
    look(1, 5, 'hB, "R3");            // hit outside class-2 mask
    look(1, 5, 'hE, "R4");            // class-2 fill -> way 2
    look(2, 5, 'hF, "R10");           // requester 2 still class 0 -> way 3
    // R9: rejected writes
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 'h00005, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");   // pulse drops
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 'h00000, "R9");
    look(0, 6, 'h10, "R9");
    look(0, 6, 'h11, "R9");
    look(0, 6, 'h12, "R9");           // still confined to ways 0..1
    // R11: same-cycle config change uses old values
    step(1, 0, 7, 'h20, 1, 0, 2, 0, 0, 0, "R11");   // class 1 -> way 0
    look(0, 7, 'h21, "R11");                        // class 2 -> way 2
    step(1, 0, 7, 'h22, 0, 0, 0, 1, 2, 'h00010, "R11"); // old mask -> way 3
    look(0, 7, 'h23, "R8");                         // new mask -> way 4
    // Constrained random traffic
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 4000; k++) begin
      int r; bit lv, cw, mw; int mv, len, pos;
      r = $urandom_range(99);
      lv = (r < 75);
      cw = ($urandom_range(99) < 6);
      mw = ($urandom_range(99) < 8);
      if ($urandom_range(1) == 1) begin
        len = $urandom_range(W, 1); pos = $urandom_range(W - len, 0);
        mv = ((1 << len) - 1) << pos;
      end else mv = $urandom & 'hFFFFF;
      step(lv, $urandom_range(NR - 1), $urandom_range(3), $urandom_range(29),
           cw, $urandom_range(NR - 1), $urandom_range(NC - 1),
           mw, $urandom_range(NC - 1), mv, "");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule